// File: doc/BRIEF.md
# Taken-Branch Redirect Cache

This block is a small fully associative store that pairs the fetch address of a branch with the address that branch jumps to. Every cycle the fetch unit presents its current fetch address on the lookup port. If a valid entry carries that address, the block raises a hit and returns the stored destination in the same cycle. The fetch unit can then steer the next fetch straight to the destination, so a taken branch costs no lost cycles.

Entries are written from the update port. Each update carries a branch address, a destination and the direction the predictor chose. The cache only ever holds branches predicted taken. When a branch is predicted taken and is not yet stored, the block allocates a slot for it. When a stored branch is later predicted not taken, the block drops its slot. A new branch goes into an empty slot if one exists. Otherwise it replaces the slot named by a rotating victim pointer. A synchronous flush empties the whole cache.

Top module: `btac`

## Requirements
- R1: After reset every lookup misses: lk_hit is 0 and lk_target is 0.
- R2: An update with up_valid=1 and up_taken=1 for an address that is not stored creates an entry. From the next cycle on, a lookup of that address gives lk_hit=1 and lk_target equal to the update's destination.
- R3: A lookup that matches no valid entry gives lk_hit=0 and lk_target=0.
- R4: A lookup in the same cycle as an update sees the contents from before that update.
- R5: A taken update for an address already stored replaces that entry's destination in place and allocates no second entry, so no other entry is evicted.
- R6: A not-taken update (up_taken=0) for a stored address removes that entry. A not-taken update for an address that is not stored changes nothing.
- R7: A new allocation takes the lowest-numbered empty slot whenever any slot is empty.
- R8: When all slots are full, a new allocation replaces the slot named by the victim pointer. The pointer starts at slot 0 after reset, advances by one on every allocation (into an empty slot or not), wraps after ENTRIES-1, and is kept across flush.
- R9: flush=1 empties every slot at the next edge and takes priority over an update in the same cycle, so every lookup misses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all entries |
| lk_addr | input | AW | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | AW | Stored destination on hit, zero on miss |
| up_valid | input | 1 | Update present this cycle |
| up_addr | input | AW | Branch address being updated |
| up_target | input | AW | Branch destination |
| up_taken | input | 1 | Predicted direction, 1 = taken |

## Verification
The bench builds the cache with ENTRIES=8 and AW=16. With eight slots, a handful of updates fills the cache. The victim pointer then wraps several times within a short run, so both eviction order and the reuse of an empty slot after an invalidation can be observed at the lookup port. A pseudo-random phase draws from a pool of sixteen addresses, twice the capacity. This mixes overwrites, invalidations and evictions far more often than the default 32 slots would allow.

// File: rtl/btac.sv
module btac #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  input  logic          up_valid,
  input  logic [AW-1:0] up_addr,
  input  logic [AW-1:0] up_target,
  input  logic          up_taken
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [AW-1:0]      tag [ENTRIES];
  logic [AW-1:0]      dst [ENTRIES];
  logic [IW-1:0]      ptr;

  logic [ENTRIES-1:0] lk_match, up_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = vld[i] && (tag[i] == lk_addr);
    assign up_match[i] = vld[i] && (tag[i] == up_addr);
  end

  assign lk_hit = |lk_match;

  always_comb begin
    lk_target = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_target = lk_target | dst[i];
  end

  logic          up_hit, has_free;
  logic [IW-1:0] up_idx, free_idx, alloc_idx;

  assign up_hit = |up_match;

  always_comb begin
    up_idx   = '0;
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (up_match[i]) up_idx = IW'(i);
      if (!vld[i]) begin
        free_idx = IW'(i);
        has_free = 1'b1;
      end
    end
  end

  assign alloc_idx = has_free ? free_idx : ptr;

  wire do_upd   = up_valid && !flush;
  wire do_alloc = do_upd && up_taken && !up_hit;
  wire do_over  = do_upd && up_taken && up_hit;
  wire do_kill  = do_upd && !up_taken && up_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      if (do_kill)  vld[up_idx]    <= 1'b0;
      if (do_alloc) begin
        vld[alloc_idx] <= 1'b1;
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      tag[alloc_idx] <= up_addr;
      dst[alloc_idx] <= up_target;
    end else if (do_over) begin
      dst[up_idx] <= up_target;
    end
  end
endmodule

module btac_chk #(
  parameter int ENTRIES = 32,
  parameter int AW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [AW-1:0]      lk_addr,
  input logic               lk_hit,
  input logic [AW-1:0]      lk_target,
  input logic               up_valid,
  input logic [AW-1:0]      up_addr,
  input logic [AW-1:0]      up_target,
  input logic               up_taken,
  input logic [ENTRIES-1:0] lk_match
);
  logic seen;
  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && flush) |=> !lk_hit);

  // R2
  alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen) && $past(up_valid && up_taken && !flush) && lk_addr == $past(up_addr))
      |-> (lk_hit && lk_target == $past(up_target)));

  // R6
  drop_on_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(seen) && $past(up_valid && !up_taken && !flush) && lk_addr == $past(up_addr))
      |-> !lk_hit);

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == '0);
endmodule

bind btac btac_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (.*);

// File: tb/tb_btac.sv
module tb_btac;
  localparam int N  = 8;
  localparam int AW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          flush = 0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          up_valid = 0;
  logic [AW-1:0] up_addr = '0;
  logic [AW-1:0] up_target = '0;
  logic          up_taken = 0;

  always #5 clk = ~clk;

  btac #(.ENTRIES(N), .AW(AW)) dut (.*);

  typedef struct {
    logic          hit;
    logic [AW-1:0] tgt;
    logic [AW-1:0] addr;
    string         req;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;

  logic          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [AW-1:0] m_t [N];
  int            m_ptr;

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic m_update(input logic [AW-1:0] a, input logic [AW-1:0] t, input logic tk);
    int hit_i = -1, free_i = -1, k;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_a[i] == a) hit_i = i;
      if (!m_v[i] && free_i < 0) free_i = i;
    end
    if (hit_i >= 0) begin
      if (tk) m_t[hit_i] = t;
      else    m_v[hit_i] = 0;
    end else if (tk) begin
      k = (free_i >= 0) ? free_i : m_ptr;
      m_v[k] = 1; m_a[k] = a; m_t[k] = t;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic step(input logic fl, input logic uv, input logic [AW-1:0] ua,
                      input logic [AW-1:0] ut, input logic tk,
                      input logic [AW-1:0] la, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    flush = fl; up_valid = uv; up_addr = ua; up_target = ut; up_taken = tk; lk_addr = la;
    e.hit = 0; e.tgt = '0; e.addr = la; e.req = req;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_a[i] == la) begin e.hit = 1; e.tgt = m_t[i]; end
    q.push_back(e);
    if (fl) m_clear();
    else if (uv) m_update(ua, ut, tk);
  endtask

  task automatic look(input logic [AW-1:0] la, input string req);
    step(0, 0, '0, '0, 0, la, req);
  endtask

  task automatic upd(input logic [AW-1:0] ua, input logic [AW-1:0] ut, input logic tk, input string req);
    step(0, 1, ua, ut, tk, ua, req);
  endtask

  task automatic scan(input string req);
    for (int i = 0; i < 16; i++) look(AW'(16'h0100 + 4 * i), req);
    look(16'h0200, req);
    look(16'h0204, req);
    look(16'h0208, req);
    look(16'h020C, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #4;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_target !== e.tgt) begin
          errors++;
          $display("FAIL %s addr=%h: hit=%b target=%h expected hit=%b target=%h",
                   e.req, e.addr, lk_hit, lk_target, e.hit, e.tgt);
        end
      end
    end
  end

  bit done = 0;
  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] lfsr = 16'hACE1;
    m_clear();
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    scan("R1");
    // R4: same-cycle lookup sees the old contents
    upd(16'h0100, 16'h0A00, 1, "R4");
    // R2
    look(16'h0100, "R2");
    for (int i = 1; i < N; i++) upd(AW'(16'h0100 + 4 * i), AW'(16'h0A00 + 16 * i), 1, "R2");
    scan("R2");
    // R3
    look(16'h0FF0, "R3");
    // R5: overwrite in place, entry for 0x0100 survives
    upd(16'h0108, 16'h0BBB, 1, "R5");
    scan("R5");
    // R8: full cache, pointer wrapped to slot 0
    upd(16'h0200, 16'h0C00, 1, "R8");
    scan("R8");
    // R6
    upd(16'h0110, 16'h0000, 0, "R6");
    look(16'h0110, "R6");
    upd(16'h0300, 16'h0D00, 0, "R6");
    look(16'h0300, "R6");
    scan("R6");
    // R7: freed slot reused before any eviction
    upd(16'h0204, 16'h0C40, 1, "R7");
    scan("R7");
    // R8: further evictions follow the pointer
    upd(16'h0208, 16'h0C80, 1, "R8");
    upd(16'h020C, 16'h0CC0, 1, "R8");
    scan("R8");
    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(0, lfsr[0], AW'(16'h0100 + 4 * lfsr[4:1]), AW'({lfsr[11:4], 4'h0}),
           lfsr[2] | lfsr[3], AW'(16'h0100 + 4 * lfsr[8:5]), "R2");
    end
    scan("R5");
    // R9: flush beats a same-cycle update
    step(1, 1, 16'h0104, 16'h0E00, 1, 16'h0104, "R9");
    scan("R9");
    upd(16'h0110, 16'h0E10, 1, "R9");
    look(16'h0110, "R9");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule